// File: doc/BRIEF.md
# Cascade Master Bit-Clock and Frame-Sync Generator

This block runs on the master clock of a serial codec that leads a cascade of devices. From three divider values (M, N, P), it derives a bit clock (SCLK) and a one-bit-wide frame-sync pulse (FS). The frame rate is the sampling rate, and one frame lasts 16·M·N·P master-clock cycles in every mode. The turbo enable changes only how fast SCLK runs inside that frame:
- In turbo mode, SCLK is the master clock divided by P, which gives 16·M·N bit clocks per frame.
- In normal mode, SCLK is the master clock divided by M·P, which gives 16·N bit clocks per frame.

Each device in the cascade owns one 16-bit slot per frame, or two slots when the programming mode is selected. Before it starts generating, the block checks that the frame can hold every slot and that the dividers are usable. If a check fails, a configuration-error flag is raised and no frame is started.

The generator loads a divider setting only at a frame boundary, or when it starts from idle. SCLK is high for the first half of each bit period and low for the second half. FS and SCLK rise on the same master-clock edge, so a receiver sampling on the falling SCLK edge sees FS stable.

Top module: `sclk_fs_master`

## Requirements
- R1: While reset is held, `sclk`, `fs` and `cfg_err` are all 0.
- R2: In turbo mode (`turbo_en`=1), one SCLK period is P master-clock cycles. SCLK is 1 for the first P/2 cycles of the period and 0 for the remaining P/2.
- R3: In normal mode (`turbo_en`=0), one SCLK period is M·P master-clock cycles. SCLK is 1 for the first half of the period and 0 for the second half.
- R4: FS repeats every 16·M·N·P master-clock cycles in both modes. A frame holds 16·M·N SCLK periods in turbo mode and 16·N SCLK periods in normal mode.
- R5: FS is 1 for exactly one SCLK period per frame, namely the first one. FS rises on the same master-clock edge as SCLK.
- R6: In turbo mode the configuration is invalid unless M·N is greater than L. L is the device count, multiplied by 2 when `prog_mode`=1.
- R7: In normal mode the configuration is invalid unless N is at least L, with L defined as in R6.
- R8: The configuration is invalid if any of the following holds: M is 0, N is 0, P is 0, P is odd, or the device count is 0.
- R9: `cfg_err` shows whether the current inputs are invalid, one master-clock cycle after they are applied. While the generator is idle with an invalid configuration, `sclk` and `fs` stay 0.
- R10: A divider, mode or count change made in the middle of a frame does not alter the running frame. It takes effect at the next frame boundary. If the new setting is invalid, generation stops at that boundary.
- R11: When the generator is idle and sees a valid configuration, it starts one master-clock cycle later. It starts with `sclk`=1 and `fs`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_m | input | DIV_W | Divider M |
| div_n | input | DIV_W | Divider N |
| div_p | input | DIV_W | Divider P (must be even) |
| turbo_en | input | 1 | 1 selects the fast bit clock (master clock / P) |
| dev_count | input | DEV_W | Number of devices in the cascade |
| prog_mode | input | 1 | 1 gives each device two slots per frame |
| sclk | output | 1 | Generated bit clock |
| fs | output | 1 | Frame-sync pulse, one SCLK period wide |
| cfg_err | output | 1 | Current configuration is invalid |

## Verification
The bench sweeps both modes over every combination of M and N from 1 to 3, P of 2 and 4, device counts 1 and 2, and both slot modes. For each valid setting, it compares every master-clock sample of SCLK and FS over more than a full frame against an arithmetic waveform. A wrong divider choice for the mode separates R2 from R3, and a wrong frame length or pulse width separates R4 from R5.

The same sweep includes settings that fail the capacity rule, which must raise the flag and keep both outputs silent. Hand-picked zero, odd-P and zero-count settings cover R8.

Two mid-frame changes show that the running frame finishes untouched:
- a valid new setting must switch period and frame length exactly at the boundary;
- an invalid one must raise the flag at once but stop the clocks only at the boundary.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  localparam int unsigned SLOT_SCLKS = 16;

  // Slots each frame must hold: one or two per device.
  function automatic int unsigned slot_count(int unsigned devs, bit prog);
    return prog ? devs * 2 : devs;
  endfunction

  // Master-clock cycles per SCLK period.
  function automatic int unsigned sclk_period(int unsigned m, int unsigned p, bit turbo);
    return turbo ? p : m * p;
  endfunction

  // SCLK periods per frame.
  function automatic int unsigned frame_sclks(int unsigned m, int unsigned n, bit turbo);
    return turbo ? SLOT_SCLKS * m * n : SLOT_SCLKS * n;
  endfunction

  // Divider sanity plus frame capacity rule.
  function automatic bit cfg_valid(int unsigned m, int unsigned n, int unsigned p,
                                   int unsigned devs, bit prog, bit turbo);
    int unsigned lanes;
    lanes = slot_count(devs, prog);
    if (m == 0 || n == 0 || p == 0 || devs == 0) return 1'b0;
    if (p[0]) return 1'b0;
    if (turbo) return (m * n) > lanes;
    return n >= lanes;
  endfunction
endpackage

// File: rtl/sfg_cfg_check.sv
module sfg_cfg_check
  import sfg_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int DEV_W = 3,
  parameter int PER_W = 8,
  parameter int FRM_W = 12
) (
  input  logic [DIV_W-1:0] div_m,
  input  logic [DIV_W-1:0] div_n,
  input  logic [DIV_W-1:0] div_p,
  input  logic [DEV_W-1:0] dev_count,
  input  logic             turbo_en,
  input  logic             prog_mode,
  output logic             cfg_ok,
  output logic [PER_W-1:0] period,
  output logic [FRM_W-1:0] flen
);
  int unsigned m32, n32, p32, d32;

  always_comb begin
    m32    = 32'(div_m);
    n32    = 32'(div_n);
    p32    = 32'(div_p);
    d32    = 32'(dev_count);
    cfg_ok = cfg_valid(m32, n32, p32, d32, prog_mode, turbo_en);
    period = PER_W'(sclk_period(m32, p32, turbo_en));
    flen   = FRM_W'(frame_sclks(m32, n32, turbo_en));
  end
endmodule

// File: rtl/sfg_sclk_div.sv
module sfg_sclk_div #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic             sclk,
  output logic             period_end
);
  logic [PER_W-1:0] cnt;

  assign period_end = run && (cnt == period - PER_W'(1));
  assign sclk       = run && (cnt < (period >> 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (period_end) cnt <= '0;
    else cnt <= cnt + PER_W'(1);
  end
endmodule

// File: rtl/sfg_frame_ctr.sv
module sfg_frame_ctr #(
  parameter int FRM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             bit_tick,
  input  logic [FRM_W-1:0] flen,
  output logic             fs,
  output logic             frame_last
);
  logic [FRM_W-1:0] bcnt;
  logic             at_last_bit;

  assign at_last_bit = (bcnt == flen - FRM_W'(1));
  assign frame_last  = bit_tick && at_last_bit;
  assign fs          = run && (bcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) bcnt <= '0;
    else if (frame_last) bcnt <= '0;
    else if (bit_tick) bcnt <= bcnt + FRM_W'(1);
  end
endmodule

// File: rtl/sclk_fs_master.sv
module sclk_fs_master
  import sfg_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int DEV_W = 3
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_m,
  input  logic [DIV_W-1:0] div_n,
  input  logic [DIV_W-1:0] div_p,
  input  logic             turbo_en,
  input  logic [DEV_W-1:0] dev_count,
  input  logic             prog_mode,
  output logic             sclk,
  output logic             fs,
  output logic             cfg_err
);
  localparam int PER_W = 2 * DIV_W;
  localparam int FRM_W = $clog2(SLOT_SCLKS) + 2 * DIV_W;

  // Internal events brought out by name for the checker.
  logic             ok_live;
  logic [PER_W-1:0] per_live, per_q;
  logic [FRM_W-1:0] len_live, len_q;
  logic             run_q, err_q;
  logic             period_end, frame_last;
  logic             sclk_w, fs_w;

  sfg_cfg_check #(.DIV_W(DIV_W), .DEV_W(DEV_W), .PER_W(PER_W), .FRM_W(FRM_W)) u_cfg (
    .div_m(div_m), .div_n(div_n), .div_p(div_p), .dev_count(dev_count),
    .turbo_en(turbo_en), .prog_mode(prog_mode),
    .cfg_ok(ok_live), .period(per_live), .flen(len_live)
  );

  sfg_sclk_div #(.PER_W(PER_W)) u_div (
    .clk(mclk), .rst_n(rst_n), .run(run_q), .period(per_q),
    .sclk(sclk_w), .period_end(period_end)
  );

  sfg_frame_ctr #(.FRM_W(FRM_W)) u_frm (
    .clk(mclk), .rst_n(rst_n), .run(run_q), .bit_tick(period_end),
    .flen(len_q), .fs(fs_w), .frame_last(frame_last)
  );

  // Settings are sampled only when idle or at the frame boundary.
  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      err_q <= 1'b0;
      per_q <= '0;
      len_q <= '0;
    end else begin
      err_q <= !ok_live;
      if (!run_q || frame_last) begin
        run_q <= ok_live;
        if (ok_live) begin
          per_q <= per_live;
          len_q <= len_live;
        end
      end
    end
  end

  assign sclk    = sclk_w;
  assign fs      = fs_w;
  assign cfg_err = err_q;
endmodule

// File: rtl/sclk_fs_master_chk.sv
module sclk_fs_master_chk #(
  parameter int PER_W = 8,
  parameter int FRM_W = 12
) (
  input logic             mclk,
  input logic             rst_n,
  input logic             sclk,
  input logic             fs,
  input logic             cfg_err,
  input logic             run_q,
  input logic             ok_live,
  input logic             period_end,
  input logic             frame_last,
  input logic [PER_W-1:0] per_q,
  input logic [FRM_W-1:0] len_q
);
  // R5
  fs_edge_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    ($rose(fs) || $fell(fs)) |-> $rose(sclk));

  // R5
  fs_width_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (fs && period_end) |=> !fs);

  // R10
  cfg_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (run_q && !frame_last) |=> ($stable(per_q) && $stable(len_q)));

  // R11
  start_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (!run_q && ok_live) |=> run_q);

  // R9
  err_set_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !ok_live |=> cfg_err);

  // R9
  err_clr_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    ok_live |=> !cfg_err);

  // R9
  idle_quiet_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !run_q |-> (!sclk && !fs));
endmodule

bind sclk_fs_master sclk_fs_master_chk #(.PER_W(PER_W), .FRM_W(FRM_W)) u_chk (
  .mclk(mclk), .rst_n(rst_n), .sclk(sclk), .fs(fs), .cfg_err(cfg_err),
  .run_q(run_q), .ok_live(ok_live), .period_end(period_end),
  .frame_last(frame_last), .per_q(per_q), .len_q(len_q)
);

// File: tb/sim_sclk_fs_master.sv
module sim_sclk_fs_master;
  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div_m = '0, div_n = '0, div_p = '0;
  logic [2:0] dev_count = '0;
  logic       turbo_en = 1'b0, prog_mode = 1'b0;
  logic       sclk, fs, cfg_err;
  int         checks = 0;
  int         errors = 0;

  always #10 mclk = ~mclk;

  sclk_fs_master u0 (
    .mclk(mclk), .rst_n(rst_n), .div_m(div_m), .div_n(div_n), .div_p(div_p),
    .turbo_en(turbo_en), .dev_count(dev_count), .prog_mode(prog_mode),
    .sclk(sclk), .fs(fs), .cfg_err(cfg_err)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected legality, restated from R6, R7 and R8.
  function automatic bit legal(int m, int n, int p, int d, bit pr, bit t);
    int need;
    need = pr ? 2 * d : d;
    if (m == 0 || n == 0 || p == 0 || d == 0 || (p % 2) == 1) return 1'b0;
    return t ? (m * n > need) : (n >= need);
  endfunction

  task automatic apply(input bit t, input int m, n, p, d, input bit pr);
    @(negedge mclk);
    rst_n = 1'b0;
    turbo_en = t; div_m = 4'(m); div_n = 4'(n); div_p = 4'(p);
    dev_count = 3'(d); prog_mode = pr;
    repeat (2) @(negedge mclk);
    rst_n = 1'b1;
    @(negedge mclk);
  endtask

  task automatic run_cfg(input bit t, input int m, n, p, d, input bit pr);
    bit ok;
    int per, frm, sbad, fbad, bad;
    string ereq;
    apply(t, m, n, p, d, pr);
    ok = legal(m, n, p, d, pr, t);
    if (m == 0 || n == 0 || p == 0 || d == 0 || (p % 2) == 1) ereq = "R8";
    else ereq = t ? "R6" : "R7";
    check(cfg_err == !ok, ereq, int'(cfg_err), int'(!ok));
    if (!ok) begin
      bad = 0;
      for (int i = 0; i < 40; i++) begin
        if (sclk || fs) bad++;
        @(negedge mclk);
      end
      check(bad == 0, "R9", bad, 0);
    end else begin
      per = t ? p : m * p;
      frm = 16 * m * n * p;
      check(sclk && fs, "R11", int'({sclk, fs}), 3);
      sbad = 0; fbad = 0;
      for (int i = 0; i < frm + 2 * per; i++) begin
        if (sclk != ((i % per) < per / 2)) sbad++;
        if (fs != ((i % frm) < per)) fbad++;
        @(negedge mclk);
      end
      check(sbad == 0, t ? "R2" : "R3", sbad, 0);
      check(fbad == 0, "R4,R5", fbad, 0);
    end
  endtask

  initial begin
    int sbad, fbad, ebad, per, frm;
    // R1: reset state
    repeat (3) @(negedge mclk);
    check(!sclk && !fs && !cfg_err, "R1", int'({sclk, fs, cfg_err}), 0);

    // Sweep of a small configuration space
    for (int t = 0; t < 2; t++)
      for (int m = 1; m <= 3; m++)
        for (int n = 1; n <= 3; n++)
          for (int p = 2; p <= 4; p += 2)
            for (int d = 1; d <= 2; d++)
              for (int pr = 0; pr < 2; pr++)
                run_cfg(t[0], m, n, p, d, pr[0]);

    // R8 corner cases
    run_cfg(1'b1, 0, 2, 2, 1, 1'b0);
    run_cfg(1'b0, 2, 0, 2, 1, 1'b0);
    run_cfg(1'b1, 2, 2, 0, 1, 1'b0);
    run_cfg(1'b1, 2, 2, 3, 1, 1'b0);
    run_cfg(1'b0, 1, 2, 2, 0, 1'b0);

    // R10: valid change in mid-frame, turbo M=2 N=2 P=2 -> M=1 P=4
    apply(1'b1, 2, 2, 2, 1, 1'b0);
    sbad = 0; fbad = 0;
    for (int i = 0; i < 128 + 136; i++) begin
      if (i < 128) begin per = 2; frm = 128; end
      else begin per = 4; frm = 128; end
      if (sclk != (((i % 128) % per) < per / 2)) sbad++;
      if (fs != (((i % 128) % frm) < per)) fbad++;
      if (i == 10) begin div_m = 4'd1; div_p = 4'd4; end
      @(negedge mclk);
    end
    check(sbad == 0, "R10", sbad, 0);
    check(fbad == 0, "R10", fbad, 0);

    // R10/R9: invalid change in mid-frame stops only at the boundary
    apply(1'b1, 2, 2, 2, 1, 1'b0);
    sbad = 0; fbad = 0; ebad = 0;
    for (int i = 0; i < 128 + 40; i++) begin
      if (cfg_err != (i >= 6)) ebad++;
      if (i < 128) begin
        if (sclk != ((i % 2) < 1)) sbad++;
        if (fs != (i < 2)) fbad++;
      end else begin
        if (sclk || fs) sbad++;
      end
      if (i == 5) div_m = 4'd0;
      @(negedge mclk);
    end
    check(ebad == 0, "R9", ebad, 0);
    check(sbad == 0, "R10", sbad, 0);
    check(fbad == 0, "R10", fbad, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mclk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule